// File: doc/BRIEF.md
# Receive-Side Automatic RTS Pacing

This block decides the level of an active-low request-to-send line for a serial receiver. Software can raise or drop the line with explicit commands. When automatic pacing is switched on, the receiver also drops the line by itself. It does this at the moment a new character begins, if the receive queue is already close to full. This gives the remote sender one character time to stop before the queue overflows.

The queue storage and the deserializer are outside the block. Each cycle they supply the current fill count and a one-cycle strobe that marks a qualified start bit. A mode input selects the queue size. In the large mode the limit is a threshold set below full, so a remote sender that reacts slowly still has room. In the small mode the limit is the last queue position. Once the queue drains below the limit, the line is raised again automatically. This happens only when the drop was made by the automatic logic. The output is registered and changes on the clock edge after the event that caused it.

Top module: `rx_rts_ctrl`

## Requirements
- R1: After reset `rts_n` is 1 (line negated) and no automatic hold is pending, so an idle cycle with pacing enabled and an empty queue leaves `rts_n` at 1.
- R2: With `auto_en`=1 and `shallow_mode`=0, a cycle with `start_valid`=1 and `fill_count` >= 240 drives `rts_n` to 1 at the next edge. With `fill_count` = 239 the strobe has no effect.
- R3: With `shallow_mode`=1 the limit is 8 (the last position of an 8-entry queue). A start strobe at fill 8 or more negates the line, and a strobe at fill 7 does not.
- R4: After an automatic negation, the first cycle with `auto_en`=1, `cmd_negate`=0 and `fill_count` below the active limit drives `rts_n` to 0 at the next edge.
- R5: A fill count at or above the limit with no start strobe never changes `rts_n`.
- R6: With `auto_en`=0, start strobes and fill levels have no effect. `rts_n` moves only on `cmd_assert` (to 0) or `cmd_negate` (to 1).
- R7: `cmd_assert` drives `rts_n` to 0 and `cmd_negate` drives it to 1 at the next edge. When both are present in the same cycle, negate wins.
- R8: A qualifying start strobe takes priority over `cmd_assert` in the same cycle. It also overrides an earlier manual assert while the fill is still at or above the limit.
- R9: A negation made by `cmd_negate` is never released automatically, whatever the fill level.
- R10: Clearing `auto_en` while an automatic negation is held cancels the hold. The line then stays negated until a command, even after `auto_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_en | input | 1 | Enables automatic pacing |
| shallow_mode | input | 1 | 1 selects the 8-entry queue limit, 0 selects the large-queue threshold |
| fill_count | input | 9 | Current receive queue occupancy |
| start_valid | input | 1 | One-cycle strobe for a qualified start bit |
| cmd_assert | input | 1 | Manual command that asserts the line (drives it low) |
| cmd_negate | input | 1 | Manual command that negates the line (drives it high) |
| rts_n | output | 1 | Active-low request-to-send, registered |

## Verification
The collision that matters is a manual assert command arriving in the same cycle as a start strobe with the queue at or above the limit. Here the automatic negation must win, and a manual negate arriving with either must still leave the line high. The random phase raises commands and strobes independently while the fill count hovers around both limits, so these overlaps happen often. Directed steps also force each pairing on purpose. Each cycle's result is compared with a bench model that applies the priority order stated in R7 and R8.

// File: rtl/rx_rts_pkg.sv
package rx_rts_pkg;
   typedef enum logic [2:0] {
      ACT_IDLE      = 3'd0,
      ACT_AUTO_DROP = 3'd1,
      ACT_MAN_DROP  = 3'd2,
      ACT_MAN_RAISE = 3'd3,
      ACT_AUTO_RISE = 3'd4,
      ACT_FORGET    = 3'd5
   } rts_act_e;
endpackage

// File: rtl/rx_rts_level.sv
module rx_rts_level #(
   parameter int CNT_W        = 9,
   parameter int DEEP_LIMIT   = 240,
   parameter int SHALLOW_SIZE = 8,
   parameter bit HAS_SHALLOW  = 1'b1
) (
   input  logic [CNT_W-1:0] fill_count,
   input  logic             shallow_mode,
   output logic             at_limit
);
   localparam logic [CNT_W-1:0] DEEP_L = CNT_W'(DEEP_LIMIT);
   localparam logic [CNT_W-1:0] SHAL_L = CNT_W'(SHALLOW_SIZE);

   generate
      if (HAS_SHALLOW) begin : g_dual
         logic [CNT_W-1:0] limit;
         assign limit    = shallow_mode ? SHAL_L : DEEP_L;
         assign at_limit = (fill_count >= limit);
      end else begin : g_single
         logic unused_mode;
         assign unused_mode = shallow_mode;
         assign at_limit    = (fill_count >= DEEP_L);
      end
   endgenerate
endmodule

// File: rtl/rx_rts_arb.sv
module rx_rts_arb
   import rx_rts_pkg::*;
(
   input  logic     auto_en,
   input  logic     start_valid,
   input  logic     at_limit,
   input  logic     cmd_assert,
   input  logic     cmd_negate,
   input  logic     hold_q,
   output rts_act_e act
);
   always_comb begin
      if (auto_en && start_valid && at_limit)
         act = ACT_AUTO_DROP;
      else if (cmd_negate)
         act = ACT_MAN_DROP;
      else if (cmd_assert)
         act = ACT_MAN_RAISE;
      else if (hold_q && auto_en && !at_limit)
         act = ACT_AUTO_RISE;
      else if (hold_q && !auto_en)
         act = ACT_FORGET;
      else
         act = ACT_IDLE;
   end
endmodule

// File: rtl/rx_rts_state.sv
module rx_rts_state
   import rx_rts_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  rts_act_e act,
   output logic     rts_n,
   output logic     hold_q
);
   logic active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         hold_q   <= 1'b0;
      end else begin
         unique case (act)
            ACT_AUTO_DROP: begin active_q <= 1'b0; hold_q <= 1'b1; end
            ACT_MAN_DROP:  begin active_q <= 1'b0; hold_q <= 1'b0; end
            ACT_MAN_RAISE: begin active_q <= 1'b1; hold_q <= 1'b0; end
            ACT_AUTO_RISE: begin active_q <= 1'b1; hold_q <= 1'b0; end
            ACT_FORGET:    hold_q <= 1'b0;
            default: ;
         endcase
      end
   end

   assign rts_n = ~active_q;
endmodule

// File: rtl/rx_rts_ctrl.sv
module rx_rts_ctrl
   import rx_rts_pkg::*;
#(
   parameter int DEEP_SIZE    = 256,
   parameter int DEEP_LIMIT   = 240,
   parameter int SHALLOW_SIZE = 8,
   parameter bit HAS_SHALLOW  = 1'b1,
   localparam int CNT_W       = $clog2(DEEP_SIZE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_en,
   input  logic             shallow_mode,
   input  logic [CNT_W-1:0] fill_count,
   input  logic             start_valid,
   input  logic             cmd_assert,
   input  logic             cmd_negate,
   output logic             rts_n
);
   generate
      if (DEEP_LIMIT < 1 || DEEP_LIMIT > DEEP_SIZE) begin : g_bad_limit
         $error("DEEP_LIMIT must lie in 1..DEEP_SIZE");
      end
      if (SHALLOW_SIZE < 1 || SHALLOW_SIZE > DEEP_SIZE) begin : g_bad_shallow
         $error("SHALLOW_SIZE must lie in 1..DEEP_SIZE");
      end
   endgenerate

   logic     at_limit;
   logic     hold_q;
   rts_act_e act;

   rx_rts_level #(
      .CNT_W(CNT_W), .DEEP_LIMIT(DEEP_LIMIT),
      .SHALLOW_SIZE(SHALLOW_SIZE), .HAS_SHALLOW(HAS_SHALLOW)
   ) i_level (
      .fill_count(fill_count), .shallow_mode(shallow_mode), .at_limit(at_limit)
   );

   rx_rts_arb i_arb (
      .auto_en(auto_en), .start_valid(start_valid), .at_limit(at_limit),
      .cmd_assert(cmd_assert), .cmd_negate(cmd_negate), .hold_q(hold_q),
      .act(act)
   );

   rx_rts_state i_state (
      .clk(clk), .rst_n(rst_n), .act(act), .rts_n(rts_n), .hold_q(hold_q)
   );
endmodule

// File: rtl/rx_rts_chk.sv
module rx_rts_chk (
   input logic clk,
   input logic rst_n,
   input logic auto_en,
   input logic start_valid,
   input logic cmd_assert,
   input logic cmd_negate,
   input logic at_limit,
   input logic hold_q,
   input logic rts_n
);
   p_auto_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && start_valid && at_limit) |=> rts_n);

   p_auto_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && auto_en && !at_limit && !cmd_negate) |=> !rts_n);

   p_no_strobe_no_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_valid && !cmd_negate && !rts_n) |=> !rts_n);

   p_off_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_en && !cmd_assert && !cmd_negate) |=> $stable(rts_n));

   p_neg_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_negate |=> rts_n);

   p_man_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_assert && !cmd_negate && !(auto_en && start_valid && at_limit)) |=> !rts_n);

   p_hold_means_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |-> rts_n);
endmodule

bind rx_rts_ctrl rx_rts_chk i_rx_rts_chk (
   .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .start_valid(start_valid),
   .cmd_assert(cmd_assert), .cmd_negate(cmd_negate), .at_limit(at_limit),
   .hold_q(hold_q), .rts_n(rts_n)
);

// File: tb/test_rx_rts_ctrl.sv
module test_rx_rts_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       auto_en = 1'b0;
   logic       shallow_mode = 1'b0;
   logic [8:0] fill_count = '0;
   logic       start_valid = 1'b0;
   logic       cmd_assert = 1'b0;
   logic       cmd_negate = 1'b0;
   logic       rts_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit m_act  = 1'b0;
   bit m_hold = 1'b0;

   always #2 clk = ~clk;

   rx_rts_ctrl i_rx_rts_ctrl (
      .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .shallow_mode(shallow_mode),
      .fill_count(fill_count), .start_valid(start_valid),
      .cmd_assert(cmd_assert), .cmd_negate(cmd_negate), .rts_n(rts_n)
   );

   function automatic int limit_of(bit sm);
      return sm ? 8 : 240;
   endfunction

   function automatic void model(bit ae, bit sm, int fc, bit sv, bit ca, bit cn);
      bit hi;
      hi = (fc >= limit_of(sm));
      if (ae && sv && hi) begin m_act = 1'b0; m_hold = 1'b1; end
      else if (cn)        begin m_act = 1'b0; m_hold = 1'b0; end
      else if (ca)        begin m_act = 1'b1; m_hold = 1'b0; end
      else if (m_hold && ae && !hi) begin m_act = 1'b1; m_hold = 1'b0; end
      else if (!ae) m_hold = 1'b0;
   endfunction

   task automatic check(input string tag);
      n_cmp++;
      if (rts_n !== ~m_act) begin
         n_bad++;
         $display("FAIL %s: rts_n=%0b expected %0b", tag, rts_n, ~m_act);
      end
   endtask

   task automatic step(input bit ae, input bit sm, input int fc, input bit sv,
                       input bit ca, input bit cn, input string tag);
      auto_en = ae; shallow_mode = sm; fill_count = 9'(fc);
      start_valid = sv; cmd_assert = ca; cmd_negate = cn;
      model(ae, sm, fc, sv, ca, cn);
      @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   function automatic int pick_fill();
      case ($urandom % 4)
         0: return 236 + int'($urandom % 9);
         1: return 5 + int'($urandom % 6);
         2: return int'($urandom % 257);
         default: return 256;
      endcase
   endfunction

   initial begin
      #(4 * 190000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      bit ae, sm;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      step(1, 0, 0, 0, 0, 0, "R1 idle after reset");
      step(1, 0, 0, 0, 1, 0, "R7 manual assert");
      step(1, 0, 250, 0, 0, 0, "R5 high fill no strobe");
      step(1, 0, 239, 1, 0, 0, "R2 strobe at 239");
      step(1, 0, 240, 1, 0, 0, "R2 strobe at 240");
      step(1, 0, 245, 0, 0, 0, "R4 still above limit");
      step(1, 0, 239, 0, 0, 0, "R4 drained below 240");
      step(1, 1, 7, 1, 0, 0, "R3 shallow strobe at 7");
      step(1, 1, 8, 1, 0, 0, "R3 shallow strobe at 8");
      step(1, 1, 7, 0, 0, 0, "R4 shallow release");
      step(1, 1, 8, 1, 1, 0, "R8 strobe beats assert");
      step(1, 1, 8, 0, 1, 0, "R7 manual assert above limit");
      step(1, 1, 8, 1, 0, 0, "R8 strobe overrides earlier assert");
      step(1, 1, 3, 0, 1, 1, "R7 both commands negate wins");
      step(1, 1, 3, 0, 0, 0, "R9 manual negate not released");
      step(1, 1, 0, 0, 0, 0, "R9 still negated");
      step(1, 1, 0, 0, 1, 0, "R7 assert again");
      step(0, 0, 256, 1, 0, 0, "R6 strobe ignored when off");
      step(0, 0, 0, 0, 0, 1, "R6 manual negate when off");
      step(0, 0, 0, 0, 0, 0, "R6 no auto release when off");
      step(0, 0, 0, 0, 1, 0, "R6 manual assert when off");
      step(1, 0, 250, 1, 0, 0, "R10 auto drop");
      step(0, 0, 0, 0, 0, 0, "R10 disable cancels hold");
      step(1, 0, 0, 0, 0, 0, "R10 no release after re-enable");
      step(1, 0, 0, 0, 1, 0, "R10 command restores");

      ae = 1'b1; sm = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 50 == 0) ae = ~ae;
         if ($urandom % 80 == 0) sm = ~sm;
         step(ae, sm, pick_fill(), ($urandom % 10) < 3, ($urandom % 12) == 0,
              ($urandom % 20) == 0, "R2/R4/R8 random");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule